// File: doc/BRIEF.md
# Filtered Command/Status Logging FIFO

This block keeps a 32-word history of serial-bus control words for a host processor to read back at its own pace. Words arrive from a serial-line decoder as a 16-bit value with a one-cycle valid strobe. The decoder also supplies a role select and a flag saying whether the word caused an access to the main RAM. The block decides whether each arriving word is worth keeping, and if it is, appends it to a circular store.

In controller role, every received status word is kept. In terminal role only command words matter to the host. A command is kept when it moved data through the main RAM. It is also kept when it is one of the two data-bearing mode commands that need the subsystem: transmit vector word and synchronize with data. All other mode commands are dropped.

The host sees the oldest kept word on a read-data port. A read strobe aimed at host address zero removes that word. Two active-low flags report whether words are held and whether the store is full.

Top module: `cmdlog_fifo`

## Requirements
- R1: While and right after synchronous reset (`rst` high), `empty_n` is 0, `full_n` is 1 and `rd_data` is 0.
- R2: When `ctrl_mode` is 1, every word presented with `word_vld` high is kept. `ram_hit` and the word contents are ignored. With `word_vld` low, nothing is kept in either role.
- R3: When `ctrl_mode` is 0, a word whose subaddress field `word_in[9:5]` is neither 0 nor 31 is kept only when `ram_hit` is 1.
- R4: When `ctrl_mode` is 0, a word whose subaddress is 0 or 31 is a mode command. It is kept only when its low field `word_in[4:0]` is 16 (transmit vector) or 17 (synchronize with data), whatever `ram_hit` is.
- R5: Kept words leave in arrival order. While at least one word is held, `rd_data` shows the oldest one. When none is held, `rd_data` is 0.
- R6: A pop happens only when `rd_en` is 1 and `rd_addr` is 0. A strobe at any other address removes nothing.
- R7: `empty_n` is 0 when no words are held and 1 when at least one is held. It updates on the clock edge after the push or pop.
- R8: `full_n` is 0 exactly while 32 words are held. A word that qualifies while the store is full is discarded, even if a pop happens in the same cycle.
- R9: A qualifying word and a pop in the same cycle, with between 1 and 31 words held, leave the count unchanged. The new word joins the tail.
- R10: A pop while the store is empty has no effect on the flags, the data or later ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_vld | input | 1 | One-cycle strobe marking `word_in` as a newly decoded word |
| ctrl_mode | input | 1 | Role select: 1 = controller (keep status words), 0 = terminal (filter commands) |
| ram_hit | input | 1 | The command in `word_in` accessed the main RAM |
| word_in | input | 16 | Decoded word: [15:11] terminal address, [10] transmit/receive, [9:5] subaddress, [4:0] count or mode code |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 8 | Host read address; 0 selects the log |
| rd_data | output | 16 | Oldest held word, 0 when empty |
| empty_n | output | 1 | 0 = no words held, 1 = words available |
| full_n | output | 1 | 0 = 32 words held, further words discarded |

## Verification
The hardest condition to reach from the ports is a full store that, in the same cycle, receives a pop and a qualifying word. The word must be dropped while the head still advances, so the count falls to 31. A directed sequence fills the store with controller-role words, then presents extra words alone and together with pops. The random phase keeps the push rate well above the pop rate, so the store returns to full many times. It also biases subaddresses toward 0 and 31 and mode codes toward 16 and 17, so the filter boundaries in R3 and R4 are hit often.

// File: rtl/cmdlog_pkg.sv
package cmdlog_pkg;

    localparam int WORD_W = 16;
    localparam int FIELD_W = 5;

    typedef struct packed {
        logic [FIELD_W-1:0] rt_addr;
        logic               xmit;
        logic [FIELD_W-1:0] sub_addr;
        logic [FIELD_W-1:0] cnt_mode;
    } cmd_word_t;

    typedef enum logic {
        ROLE_TERM = 1'b0,
        ROLE_CTRL = 1'b1
    } log_role_e;

    localparam logic [FIELD_W-1:0] SA_MODE_LO = 5'd0;
    localparam logic [FIELD_W-1:0] SA_MODE_HI = 5'd31;
    localparam logic [FIELD_W-1:0] MC_TX_VECTOR = 5'd16;
    localparam logic [FIELD_W-1:0] MC_SYNC_DATA = 5'd17;

    function automatic logic is_mode_cmd(cmd_word_t c);
        return (c.sub_addr == SA_MODE_LO) || (c.sub_addr == SA_MODE_HI);
    endfunction

    function automatic logic mode_cmd_wanted(cmd_word_t c);
        return (c.cnt_mode == MC_TX_VECTOR) || (c.cnt_mode == MC_SYNC_DATA);
    endfunction

endpackage

// File: rtl/cmdlog_filter.sv
module cmdlog_filter
    import cmdlog_pkg::*;
(
    input  logic      word_vld,
    input  log_role_e role,
    input  logic      ram_hit,
    input  cmd_word_t word,
    output logic      admit
);

    logic term_admit;

    always_comb begin
        if (is_mode_cmd(word)) begin
            term_admit = mode_cmd_wanted(word);
        end else begin
            term_admit = ram_hit;
        end
    end

    always_comb begin
        unique case (role)
            ROLE_CTRL: admit = word_vld;
            ROLE_TERM: admit = word_vld && term_admit;
            default:   admit = 1'b0;
        endcase
    end

endmodule

// File: rtl/cmdlog_ctrl.sv
module cmdlog_ctrl #(
    parameter int DEPTH = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             do_push,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic             empty_n,
    output logic             full_n
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic do_pop;
    logic is_full;
    logic is_empty;

    assign is_full  = (count == FULL_CNT);
    assign is_empty = (count == '0);
    assign do_push  = push_req && !is_full;
    assign do_pop   = pop_req && !is_empty;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_n <= 1'b0;
            full_n  <= 1'b1;
        end else begin
            case ({do_push, do_pop})
                2'b10: begin
                    empty_n <= 1'b1;
                    full_n  <= (count != FULL_CNT - 1'b1);
                end
                2'b01: begin
                    empty_n <= (count != CNT_W'(1));
                    full_n  <= 1'b1;
                end
                default: begin
                    empty_n <= empty_n;
                    full_n  <= full_n;
                end
            endcase
        end
    end

    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (is_full && push_req && pop_req) |=> (count == FULL_CNT - 1'b1));

    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (is_full && !pop_req) |=> (count == FULL_CNT));

    // R9
    both_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req && !is_full && !is_empty) |=> $stable(count));

    // R10
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (is_empty && !push_req) |=> (count == '0));

    // R7
    empty_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(empty_n) |-> $past(push_req));

endmodule

// File: rtl/cmdlog_store.sv
module cmdlog_store
    import cmdlog_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/cmdlog_fifo.sv
module cmdlog_fifo
    import cmdlog_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int HOST_AW = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               word_vld,
    input  logic               ctrl_mode,
    input  logic               ram_hit,
    input  logic [WORD_W-1:0]  word_in,
    input  logic               rd_en,
    input  logic [HOST_AW-1:0] rd_addr,
    output logic [WORD_W-1:0]  rd_data,
    output logic               empty_n,
    output logic               full_n
);

    cmd_word_t         word_s;
    log_role_e         role_s;
    logic              admit;
    logic              pop_req;
    logic              do_push;
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  count;
    logic [WORD_W-1:0] head;

    assign word_s  = cmd_word_t'(word_in);
    assign role_s  = log_role_e'(ctrl_mode);
    assign pop_req = rd_en && (rd_addr == '0);

    cmdlog_filter u_filter (
        .word_vld (word_vld),
        .role     (role_s),
        .ram_hit  (ram_hit),
        .word     (word_s),
        .admit    (admit)
    );

    cmdlog_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .push_req (admit),
        .pop_req  (pop_req),
        .do_push  (do_push),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .count    (count),
        .empty_n  (empty_n),
        .full_n   (full_n)
    );

    cmdlog_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (do_push),
        .waddr (wr_ptr),
        .wdata (word_in),
        .raddr (rd_ptr),
        .rdata (head)
    );

    assign rd_data = empty_n ? head : '0;

    // R2
    ctrl_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_mode && word_vld && full_n) |=> empty_n);

    // R4
    mc_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_mode && is_mode_cmd(word_s) && !mode_cmd_wanted(word_s)) |-> !admit);

    // R6
    addr_nopop_chk: assert property (@(posedge clk) disable iff (rst)
        (!admit && !pop_req && count != '0) |=> (empty_n && $stable(rd_data)));

endmodule

// File: tb/sim_cmdlog_fifo.sv
module sim_cmdlog_fifo;

    logic        clk = 1'b0;
    logic        rst;
    logic        word_vld;
    logic        ctrl_mode;
    logic        ram_hit;
    logic [15:0] word_in;
    logic        rd_en;
    logic [7:0]  rd_addr;
    logic [15:0] rd_data;
    logic        empty_n;
    logic        full_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [15:0] mq [32];
    int          mcnt = 0;

    always #5 clk = ~clk;

    cmdlog_fifo u0 (
        .clk(clk), .rst(rst), .word_vld(word_vld), .ctrl_mode(ctrl_mode),
        .ram_hit(ram_hit), .word_in(word_in), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .empty_n(empty_n), .full_n(full_n)
    );

    function automatic bit want(bit m, bit rh, logic [15:0] w);
        logic [4:0] sa;
        logic [4:0] mc;
        sa = w[9:5];
        mc = w[4:0];
        if (m) return 1'b1;
        if (sa == 5'd0 || sa == 5'd31) return (mc == 5'd16 || mc == 5'd17);
        return rh;
    endfunction

    function automatic logic [15:0] mkword(logic [4:0] ta, bit tr, logic [4:0] sa, logic [4:0] mc);
        return {ta, tr, sa, mc};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_outs(string tag);
        logic [15:0] eh;
        eh = (mcnt > 0) ? mq[0] : 16'h0;
        chk(empty_n == (mcnt > 0), {tag, " empty_n"}, 16'(empty_n), 16'(mcnt > 0));
        chk(full_n == (mcnt != 32), {tag, " full_n"}, 16'(full_n), 16'(mcnt != 32));
        chk(rd_data == eh, {tag, " rd_data"}, rd_data, eh);
    endtask

    task automatic step(bit v, bit m, bit rh, logic [15:0] w, bit re, logic [7:0] ra, string tag);
        bit adm;
        bit pop;
        bit push;
        @(negedge clk);
        word_vld  = v;
        ctrl_mode = m;
        ram_hit   = rh;
        word_in   = w;
        rd_en     = re;
        rd_addr   = ra;
        adm  = v && want(m, rh, w);
        pop  = re && (ra == 8'd0) && (mcnt > 0);
        push = adm && (mcnt < 32);
        @(posedge clk);
        #1;
        if (pop) begin
            for (int i = 0; i < 31; i++) mq[i] = mq[i+1];
            mcnt--;
        end
        if (push) begin
            mq[mcnt] = w;
            mcnt++;
        end
        check_outs(tag);
    endtask

    task automatic idle_pop(string tag);
        step(1'b0, 1'b0, 1'b0, 16'h0, 1'b1, 8'd0, tag);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles >= 200000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; word_vld = 0; ctrl_mode = 0; ram_hit = 0;
        word_in = 0; rd_en = 0; rd_addr = 0;
        repeat (3) @(posedge clk);
        #1;
        check_outs("R1 in reset");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check_outs("R1 after reset");

        // R10 pop while empty
        idle_pop("R10");
        idle_pop("R10");
        step(1'b1, 1'b1, 1'b0, 16'hA5A5, 1'b0, 8'd0, "R10 push after empty pops");
        idle_pop("R5");

        // R3 terminal normal commands
        step(1'b1, 1'b0, 1'b1, mkword(5'd3, 1'b1, 5'd5, 5'd4), 1'b0, 8'd0, "R3 ram hit kept");
        step(1'b1, 1'b0, 1'b0, mkword(5'd3, 1'b0, 5'd6, 5'd2), 1'b0, 8'd0, "R3 no ram dropped");
        step(1'b1, 1'b0, 1'b1, mkword(5'd7, 1'b0, 5'd30, 5'd16), 1'b0, 8'd0, "R3 sa30 kept");
        // R4 mode commands
        step(1'b1, 1'b0, 1'b0, mkword(5'd1, 1'b1, 5'd0, 5'd16), 1'b0, 8'd0, "R4 sa0 mc16 kept");
        step(1'b1, 1'b0, 1'b1, mkword(5'd1, 1'b1, 5'd31, 5'd17), 1'b0, 8'd0, "R4 sa31 mc17 kept");
        step(1'b1, 1'b0, 1'b1, mkword(5'd1, 1'b1, 5'd0, 5'd2), 1'b0, 8'd0, "R4 mc2 dropped");
        step(1'b1, 1'b0, 1'b1, mkword(5'd1, 1'b0, 5'd31, 5'd18), 1'b0, 8'd0, "R4 mc18 dropped");
        // R2 no valid, nothing kept
        step(1'b0, 1'b1, 1'b1, 16'hFFFF, 1'b0, 8'd0, "R2 no valid");
        // R6 wrong address does not pop
        step(1'b0, 1'b0, 1'b0, 16'h0, 1'b1, 8'd1, "R6 addr1");
        step(1'b0, 1'b0, 1'b0, 16'h0, 1'b1, 8'd128, "R6 addr128");
        // R5 drain in order
        while (mcnt > 0) idle_pop("R5 drain");
        idle_pop("R10 drained");

        // R8 fill in controller role
        for (int i = 0; i < 32; i++)
            step(1'b1, 1'b1, 1'b0, 16'(16'h1000 + i), 1'b0, 8'd0, "R2 fill");
        step(1'b1, 1'b1, 1'b0, 16'hDEAD, 1'b0, 8'd0, "R8 push when full");
        step(1'b1, 1'b1, 1'b0, 16'hBEEF, 1'b1, 8'd0, "R8 push and pop when full");
        // R9 simultaneous at 31
        step(1'b1, 1'b1, 1'b0, 16'hC0DE, 1'b1, 8'd0, "R9 push and pop");
        step(1'b1, 1'b0, 1'b1, mkword(5'd9, 1'b1, 5'd9, 5'd9), 1'b1, 8'd0, "R9 push and pop");
        while (mcnt > 0) idle_pop("R8 drain");

        // random phase
        for (int n = 0; n < 3000; n++) begin
            bit v, m, rh, re;
            logic [4:0] sa, mc;
            logic [7:0] ra;
            v  = ($urandom_range(0, 99) < 70);
            m  = $urandom_range(0, 1);
            rh = $urandom_range(0, 1);
            case ($urandom_range(0, 3))
                0: sa = 5'd0;
                1: sa = 5'd31;
                default: sa = 5'($urandom_range(0, 31));
            endcase
            case ($urandom_range(0, 3))
                0: mc = 5'd16;
                1: mc = 5'd17;
                default: mc = 5'($urandom_range(0, 31));
            endcase
            re = ($urandom_range(0, 99) < 40);
            ra = ($urandom_range(0, 99) < 80) ? 8'd0 : 8'($urandom_range(1, 255));
            step(v, m, rh, mkword(5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)), sa, mc),
                 re, ra, "R5 random");
        end
        finish_run();
    end

endmodule